// File: doc/BRIEF.md
# Inter-Processor Doorbell Message Unit

This unit lets the cores of a small cluster ring doorbells at each other. Every core has its own command port: a valid strobe, a send/clear selector and a 32-bit message word. A message word holds a 5-bit type in bits [31:27], a broadcast flag in bit 26, bits [25:14] reserved and required to be zero, and a 14-bit target tag in bits [13:0]. The type is decoded into one of three doorbell classes: normal, critical or hypervisor. A send raises that class's pending bit in every addressed core. A clear drops the issuing core's own pending bit for that class.

A single mode input chooses between two decode rules. In embedded mode, type 0 means normal and type 1 means critical. Types 2, 3 and 4 are guest doorbell types that this unit does not handle, and every other type is reserved. Embedded sends address cores by processor-ID match or by broadcast. In server mode, type 5 (hypervisor) is the only valid type. Addressing uses the processor-ID tag alone, and the broadcast flag is ignored.

Pending bits are exported per core, with bit index core*3 + class, where normal=0, critical=1 and hypervisor=2. A per-bit acknowledge input, driven when a core takes the interrupt, clears them. Each pending bit updates on the clock edge that follows the command.

Top module: `dbell_unit`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every pending bit is 0.
- R2: In embedded mode, a send of type 0 sets the normal bit (index core*3+0) in each addressed core.
- R3: In embedded mode, a send of type 1 sets the critical bit (index core*3+1) in each addressed core.
- R4: In embedded mode, a send or clear of type 2, 3, 4, 5 or any type from 6 to 31 changes no pending bit.
- R5: In embedded mode, a send with bit 26 set addresses every core, whatever the tag.
- R6: A send addresses every core whose processor ID equals bits [13:0], including several cores that share an ID.
- R7: In server mode, a send of type 5 sets the hypervisor bit (index core*3+2). Every other type is a no-op for both send and clear.
- R8: In server mode, bit 26 is ignored, and only cores whose ID matches the tag are addressed.
- R9: A clear drops only the issuing core's bit for the decoded class. The tag field of a clear is ignored.
- R10: A clear with an invalid type leaves all pending bits unchanged.
- R11: An acknowledge bit clears the matching pending bit on the next edge.
- R12: When a send sets a bit in the same cycle that a clear from its owner or an acknowledge drops it, the bit ends up set.
- R13: A message with any of bits [25:14] nonzero is treated as reserved and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| server_mode | input | 1 | 1 selects server decode, 0 selects embedded decode |
| cmd_valid | input | NCORE | Per-core command strobe |
| cmd_clear | input | NCORE | Per-core command kind: 1 for clear, 0 for send |
| cmd_msg | input | NCORE*32 | Per-core message words; core i uses bits [i*32 +: 32] |
| core_pid | input | NCORE*14 | Processor ID of each core |
| ack | input | NCORE*3 | Per-bit acknowledge, which clears the pending bit |
| pending | output | NCORE*3 | Pending doorbell bits, indexed core*3+class |

## Verification
A pending bit can be raised by another core's send in the same cycle that its owner issues a clear for that class, or that the core acknowledges it. The bench provokes this by having core 0 send a normal doorbell to cores 1 and 2, while core 1 clears its own normal class and the acknowledge for core 2's normal bit is held high, all in one cycle. Both bits must read as set after that edge. A table of single commands in both modes, followed by a separate acknowledge step, confirms that each removal path works when no send competes with it.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    localparam int MSGW      = 32;
    localparam int TYPEW     = 5;
    localparam int TAGW      = 14;
    localparam int TYPE_LSB  = 27;
    localparam int BCAST_BIT = 26;
    localparam int RSV_LSB   = TAGW;
    localparam int RSV_MSB   = BCAST_BIT - 1;
    localparam int NCLS      = 3;

    // class index within each core's pending group
    localparam int CLS_NORM = 0;
    localparam int CLS_CRIT = 1;
    localparam int CLS_HYP  = 2;

    typedef enum logic [TYPEW-1:0] {
        MT_NORM    = 5'd0,
        MT_CRIT    = 5'd1,
        MT_GNORM   = 5'd2,
        MT_GCRIT   = 5'd3,
        MT_GMCHK   = 5'd4,
        MT_HYP     = 5'd5
    } msg_type_e;

    typedef struct packed {
        logic [NCLS-1:0] pend;
    } slot_state_t;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
(
    input  logic            server_mode,
    input  logic [MSGW-1:0] msg,
    output logic [NCLS-1:0] cls
);
    logic [TYPEW-1:0] mtype;
    logic             rsv_ok;

    always_comb begin
        mtype  = msg[TYPE_LSB +: TYPEW];
        rsv_ok = (msg[RSV_MSB:RSV_LSB] == '0);
        cls    = '0;
        if (rsv_ok) begin
            if (server_mode) begin
                if (mtype == MT_HYP) cls[CLS_HYP] = 1'b1;
            end else begin
                case (mtype)
                    MT_NORM:  cls[CLS_NORM] = 1'b1;
                    MT_CRIT:  cls[CLS_CRIT] = 1'b1;
                    // guest classes are not serviced here: no-op
                    MT_GNORM, MT_GCRIT, MT_GMCHK: cls = '0;
                    default:  cls = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dbell_match.sv
module dbell_match
    import dbell_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                  server_mode,
    input  logic                  bcast,
    input  logic [TAGW-1:0]       tag,
    input  logic [NCORE*TAGW-1:0] core_pid,
    output logic [NCORE-1:0]      hit
);
    logic bcast_eff;

    always_comb begin
        // broadcast only honoured in embedded mode
        bcast_eff = bcast & ~server_mode;
        for (int j = 0; j < NCORE; j++) begin
            hit[j] = bcast_eff | (core_pid[j*TAGW +: TAGW] == tag);
        end
    end
endmodule

// File: rtl/dbell_slot.sv
module dbell_slot
    import dbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] set,
    input  logic [NCLS-1:0] clr,
    input  logic [NCLS-1:0] ack,
    output logic [NCLS-1:0] pend
);
    slot_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr & ~ack) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    // R12: a set always lands, whatever clears it in the same cycle
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & $past(set)) == $past(set)));

    // R11: acknowledged bits without a competing set drop
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & $past(ack & ~set)) == '0));

    // R9: a bit never appears without a set
    a_r9_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(set)) == '0));
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
    import dbell_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  server_mode,
    input  logic [NCORE-1:0]      cmd_valid,
    input  logic [NCORE-1:0]      cmd_clear,
    input  logic [NCORE*MSGW-1:0] cmd_msg,
    input  logic [NCORE*TAGW-1:0] core_pid,
    input  logic [NCORE*NCLS-1:0] ack,
    output logic [NCORE*NCLS-1:0] pending
);
    logic [NCORE-1:0][NCLS-1:0]  cls;
    logic [NCORE-1:0][NCORE-1:0] hit;
    logic [NCORE-1:0][NCLS-1:0]  set_v;
    logic [NCORE-1:0][NCLS-1:0]  clr_v;
    logic [NCORE-1:0]            send;

    for (genvar i = 0; i < NCORE; i++) begin : g_issuer
        dbell_decode u_dec (
            .server_mode (server_mode),
            .msg         (cmd_msg[i*MSGW +: MSGW]),
            .cls         (cls[i])
        );
        dbell_match #(.NCORE(NCORE)) u_match (
            .server_mode (server_mode),
            .bcast       (cmd_msg[i*MSGW + BCAST_BIT]),
            .tag         (cmd_msg[i*MSGW +: TAGW]),
            .core_pid    (core_pid),
            .hit         (hit[i])
        );
    end

    always_comb begin
        send  = cmd_valid & ~cmd_clear;
        set_v = '0;
        for (int i = 0; i < NCORE; i++) begin
            for (int j = 0; j < NCORE; j++) begin
                set_v[j] = set_v[j] | ({NCLS{send[i] & hit[i][j]}} & cls[i]);
            end
        end
        for (int j = 0; j < NCORE; j++) begin
            clr_v[j] = {NCLS{cmd_valid[j] & cmd_clear[j]}} & cls[j];
        end
    end

    for (genvar j = 0; j < NCORE; j++) begin : g_core
        dbell_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[j]),
            .clr   (clr_v[j]),
            .ack   (ack[j*NCLS +: NCLS]),
            .pend  (pending[j*NCLS +: NCLS])
        );

        // R7: hypervisor class only rises after a server-mode cycle
        a_r7_hyp_needs_server: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[j*NCLS + CLS_HYP]) |-> $past(server_mode));

        // R2 / R3: normal and critical classes only rise from embedded decode
        a_r2_emb_classes: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pending[j*NCLS + CLS_NORM]) || $rose(pending[j*NCLS + CLS_CRIT]))
            |-> !$past(server_mode));
    end

    // R1: nothing pending on the edge right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (pending == '0));
endmodule

// File: tb/sim_dbell_unit.sv
`timescale 1ns/1ps
module sim_dbell_unit;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            server_mode;
    logic [N-1:0]    cmd_valid;
    logic [N-1:0]    cmd_clear;
    logic [N*32-1:0] cmd_msg;
    logic [N*14-1:0] core_pid;
    logic [N*3-1:0]  ack;
    logic [N*3-1:0]  pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dbell_unit #(.NCORE(N)) u0 (
        .clk(clk), .rst_n(rst_n), .server_mode(server_mode),
        .cmd_valid(cmd_valid), .cmd_clear(cmd_clear), .cmd_msg(cmd_msg),
        .core_pid(core_pid), .ack(ack), .pending(pending)
    );

    // {srv, issuer[1:0], clr, type[4:0], bcast, rsv[11:0], tag[13:0], expected[11:0]}
    localparam logic [47:0] VEC [15] = '{
        {1'b0,2'd0,1'b0,5'd0,1'b0,12'h000,14'd9,12'h048}, // R2 R6 two cores share id 9
        {1'b0,2'd1,1'b0,5'd1,1'b1,12'h000,14'd0,12'h4DA}, // R3 R5 broadcast critical
        {1'b0,2'd2,1'b0,5'd2,1'b0,12'h000,14'd7,12'h4DA}, // R4 guest normal
        {1'b0,2'd2,1'b0,5'd4,1'b1,12'h000,14'd0,12'h4DA}, // R4 guest machine-check
        {1'b0,2'd3,1'b0,5'd5,1'b0,12'h000,14'd3,12'h4DA}, // R4 type 5 in embedded
        {1'b0,2'd0,1'b0,5'd0,1'b0,12'h040,14'd3,12'h4DA}, // R13 reserved bit set
        {1'b0,2'd1,1'b1,5'd0,1'b0,12'h000,14'd7,12'h4D2}, // R9 own clear, tag ignored
        {1'b0,2'd0,1'b1,5'd3,1'b0,12'h000,14'd0,12'h4D2}, // R10 R4 guest clear
        {1'b1,2'd0,1'b0,5'd5,1'b0,12'h000,14'd3,12'h0CD2}, // R7 hypervisor send
        {1'b1,2'd3,1'b0,5'd5,1'b1,12'h000,14'd9,12'hDF2}, // R8 bcast ignored
        {1'b1,2'd0,1'b0,5'd0,1'b0,12'h000,14'd9,12'hDF2}, // R7 type 0 in server
        {1'b1,2'd0,1'b0,5'd1,1'b1,12'h000,14'd0,12'hDF2}, // R7 type 1 in server
        {1'b1,2'd2,1'b1,5'd5,1'b0,12'h000,14'd0,12'hCF2}, // R9 hypervisor clear
        {1'b1,2'd2,1'b1,5'd0,1'b0,12'h000,14'd0,12'hCF2}, // R10 R7 invalid clear
        {1'b0,2'd3,1'b1,5'd1,1'b0,12'h000,14'd0,12'h8F2}  // R9 critical clear
    };
    localparam int VREQ [15] = '{2, 3, 4, 4, 4, 13, 9, 10, 7, 8, 7, 7, 9, 10, 9};

    task automatic check(input string req, input logic [11:0] exp);
        checks++;
        if (pending !== exp) begin
            fails++;
            $display("FAIL %s pending=%h expected=%h", req, pending, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = '0; cmd_clear = '0; cmd_msg = '0; ack = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        core_pid    = {14'd3, 14'd9, 14'd9, 14'd7}; // core3..core0
        server_mode = 1'b0;
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int n = 0; n < 15; n++) begin
            logic [47:0] v;
            int iss;
            v = VEC[n];
            @(negedge clk);
            iss = int'(v[46:45]);
            server_mode = v[47];
            cmd_valid[iss] = 1'b1;
            cmd_clear[iss] = v[44];
            cmd_msg[iss*32 +: 32] = v[43:12];
            step();
            check($sformatf("R%0d vector %0d", VREQ[n], n), v[11:0]);
        end

        // R11: acknowledge core 3 hypervisor bit (index 11)
        @(negedge clk);
        server_mode = 1'b0;
        ack[11] = 1'b1;
        ack[0]  = 1'b1; // already clear, stays clear
        step();
        check("R11 ack", 12'h0F2);

        // R12: send to cores 1,2 normal while core1 clears and core2 is acked
        @(negedge clk);
        cmd_valid = 4'b0011;
        cmd_clear = 4'b0010;
        cmd_msg[0*32 +: 32]  = {5'd0, 1'b0, 12'h000, 14'd9};
        cmd_msg[1*32 +: 32]  = {5'd0, 1'b0, 12'h000, 14'd0};
        ack[6] = 1'b1;
        step();
        check("R12 collision", 12'h0FA);

        // R1: reset in mid run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 reset mid run", 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", 12'h000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule